// File: doc/BRIEF.md
# Error Record Store Controller

This block is the platform side of a small persistent store for fixed-size error records. A host talks to it through single-cycle actions. It opens an operation (store, fetch or discard a record). It then sets a word offset into a staging buffer and a 64-bit record identifier, starts the operation and polls until the controller is no longer busy. Last, it reads back a status code and an identifier, and closes the operation. The staging buffer is inside the block and the host can also reach it through a simple word port. The controller copies records one word per cycle between that buffer and an internal slot memory. It keeps an occupancy bit and an identifier for each slot, and it keeps a count of stored records.

Every record is `RW` 64-bit words long. Word 0 is a header: a 16-bit signature sits in bits 15:0 and 48 bits of free bookkeeping sit above it. Word 1 holds the record identifier. Slots are searched by identifier. When a lookup needs a "first" or "next" record, the lowest occupied slot counts as first and the ordering follows slot index.

Top module: `erc_top`

## Requirements
- R1: An action is taken when act_valid is high at a clock edge. The codes are 0 open-store, 1 open-fetch, 2 open-discard, 3 set offset (act_data low bits), 4 set identifier (act_data), 5 execute, 6 busy query (act_rdata bit 0), 7 status query (act_rdata[7:0]), 8 identifier query (act_rdata), 9 close. Query results appear on act_rdata combinationally from act_code. After reset, busy is 0, rec_count is 0, the status is 0 and the identifier register is 0.
- R2: The cycle after an accepted execute, busy is 1. It stays 1 until the operation completes and then returns to 0. The busy query returns the same value in bit 0. The status changes only while busy.
- R3: A store is rejected with status 3 when the record at the offset lacks the signature 16'h5245 in word 0 bits 15:0, or when its identifier (word 1) is 0. No slot and no count change.
- R4: A store whose identifier is not held takes the lowest free slot and copies RW words from buffer offset onward. rec_count rises by 1 and the status is 0.
- R5: A store whose identifier is already held overwrites that slot in place. rec_count is unchanged and the status is 0.
- R6: A store to a full store with no matching identifier gives status 3 and leaves rec_count unchanged.
- R7: A fetch with identifier 0 copies the lowest occupied slot into the buffer at the offset and gives status 0.
- R8: A fetch with a nonzero identifier that is held copies that record into the buffer at the offset and gives status 0.
- R9: A fetch with a nonzero identifier that is not held gives status 5. It loads the identifier register with the identifier of the lowest occupied slot and leaves the buffer untouched.
- R10: A fetch when rec_count is 0 gives status 4.
- R11: After a successful fetch, the identifier register holds the identifier of the next occupied slot above the one fetched. When there is none, it holds all ones.
- R12: A discard with identifier 0 gives status 3. A discard of an identifier that is not held gives status 5. A discard of a held identifier frees the slot, lowers rec_count by 1 and gives status 0.
- R13: While busy, the open, set, execute and close actions have no effect, and host writes to the buffer are dropped.
- R14: An execute with no open operation (after reset or after a close) gives status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Action strobe |
| act_code | input | 4 | Action code |
| act_data | input | 64 | Action argument (offset or identifier) |
| act_rdata | output | 64 | Query result for the code on act_code |
| buf_we | input | 1 | Host write to staging buffer |
| buf_addr | input | BAW | Staging buffer word address |
| buf_wdata | input | 64 | Staging buffer write data |
| buf_rdata | output | 64 | Staging buffer read data at buf_addr |
| busy | output | 1 | Operation in progress |
| rec_count | output | CNTW | Number of occupied slots |

## Verification
The bench fills every slot and then tries one more new identifier. A design that allocated past the end, or that bumped the count before it checked for a free slot, would show a count above the slot total or a status of 0. A fetch of a missing identifier is checked against marker words already sitting in the buffer. A controller that copied some slot anyway would overwrite them. The same check catches a controller that forgot to load the first identifier. Fetching the top occupied slot must return all ones, and fetching after a discard must skip the freed slot. An iterator that wrapped around or read stale occupancy would return the wrong identifier. Set-identifier and buffer writes issued during a copy must leave no trace. A controller that accepted them would show a changed identifier or a corrupted marker word.

// File: rtl/erc_pkg.sv
package erc_pkg;
  localparam logic [15:0] REC_SIG = 16'h5245;

  typedef enum logic [3:0] {
    A_OPEN_ST  = 4'd0,
    A_OPEN_FE  = 4'd1,
    A_OPEN_DI  = 4'd2,
    A_SET_OFF  = 4'd3,
    A_SET_ID   = 4'd4,
    A_EXEC     = 4'd5,
    A_Q_BUSY   = 4'd6,
    A_Q_STAT   = 4'd7,
    A_Q_ID     = 4'd8,
    A_CLOSE    = 4'd9
  } act_e;

  typedef enum logic [1:0] {OP_NONE, OP_ST, OP_FE, OP_DI} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_COPY} st_e;

  localparam logic [7:0] STS_OK    = 8'h00;
  localparam logic [7:0] STS_FAIL  = 8'h03;
  localparam logic [7:0] STS_EMPTY = 8'h04;
  localparam logic [7:0] STS_NOREC = 8'h05;

  function automatic logic hdr_ok(input logic [63:0] w);
    return w[15:0] == REC_SIG;
  endfunction

  function automatic logic [63:0] end_marker();
    return {64{1'b1}};
  endfunction
endpackage

// File: rtl/erc_slot_lookup.sv
module erc_slot_lookup #(
  parameter int NSLOT = 4,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]        occ,
  input  logic [NSLOT-1:0][63:0]  ids,
  input  logic [63:0]             key,
  input  logic [SW-1:0]           cur,
  output logic                    hit,
  output logic [SW-1:0]           hit_idx,
  output logic                    free_any,
  output logic [SW-1:0]           free_idx,
  output logic [SW-1:0]           first_idx,
  output logic                    next_any,
  output logic [SW-1:0]           next_idx
);
  always_comb begin
    hit = 1'b0;      hit_idx = '0;
    free_any = 1'b0; free_idx = '0;
    first_idx = '0;
    next_any = 1'b0; next_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (occ[i] && ids[i] == key) begin
        hit = 1'b1;
        hit_idx = SW'(i);
      end
      if (!occ[i]) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end
      if (occ[i]) first_idx = SW'(i);
      if (occ[i] && SW'(i) > cur) begin
        next_any = 1'b1;
        next_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/erc_copy_seq.sv
module erc_copy_seq #(
  parameter int RW = 4,
  localparam int CW = $clog2(RW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = active && (cnt == CW'(RW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/erc_stage_buf.sv
module erc_stage_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [63:0]   host_wdata,
  output logic [63:0]   host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [63:0]   eng_wdata,
  output logic [63:0]   eng_rdata0,
  output logic [63:0]   eng_rdata1
);
  logic [63:0] mem [DEPTH];
  logic [AW-1:0] eng_addr1;

  assign eng_addr1  = eng_addr + AW'(1);
  assign host_rdata = mem[host_addr];
  assign eng_rdata0 = mem[eng_addr];
  assign eng_rdata1 = mem[eng_addr1];

  always_ff @(posedge clk) begin
    if (eng_we)       mem[eng_addr]  <= eng_wdata;
    else if (host_we) mem[host_addr] <= host_wdata;
  end
endmodule

// File: rtl/erc_top.sv
module erc_top
  import erc_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int RW        = 4,
  parameter int BUF_WORDS = 16,
  localparam int SW    = $clog2(NSLOT),
  localparam int CW    = $clog2(RW),
  localparam int BAW   = $clog2(BUF_WORDS),
  localparam int CNTW  = $clog2(NSLOT + 1),
  localparam int SDEP  = NSLOT * RW,
  localparam int SAW   = $clog2(SDEP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_valid,
  input  logic [3:0]      act_code,
  input  logic [63:0]     act_data,
  output logic [63:0]     act_rdata,
  input  logic            buf_we,
  input  logic [BAW-1:0]  buf_addr,
  input  logic [63:0]     buf_wdata,
  output logic [63:0]     buf_rdata,
  output logic            busy,
  output logic [CNTW-1:0] rec_count
);
  st_e                    st_q;
  op_e                    op_q;
  logic [BAW-1:0]         off_q;
  logic [63:0]            id_q;
  logic [7:0]             status_q;
  logic [CNTW-1:0]        count_q;
  logic [SW-1:0]          slot_q;
  logic                   new_q;
  logic [63:0]            wid_q;
  logic [NSLOT-1:0]       occ_q;
  logic [NSLOT-1:0][63:0] sid_q;
  logic [63:0]            store_mem [SDEP];

  // copy engine wires
  logic          seq_start, seq_active, seq_last;
  logic [CW-1:0] seq_cnt;
  logic [BAW-1:0] eng_addr;
  logic [63:0]   w0, w1, store_rd;
  logic [SAW-1:0] store_addr;
  logic          store_we, eng_we, done_evt;

  // lookup wires
  logic [63:0]   key;
  logic          hit, free_any, next_any;
  logic [SW-1:0] hit_idx, free_idx, first_idx, next_idx;

  // decision wires
  logic          go_copy, pick_new, drop_slot, load_first;
  logic [SW-1:0] pick_slot;
  logic [7:0]    look_status;

  assign busy      = (st_q != ST_IDLE);
  assign rec_count = count_q;
  assign eng_addr  = off_q + BAW'(seq_cnt);
  assign store_addr = SAW'(slot_q) * SAW'(RW) + SAW'(seq_cnt);
  assign store_rd  = store_mem[store_addr];
  assign store_we  = (st_q == ST_COPY) && seq_active && (op_q == OP_ST);
  assign eng_we    = (st_q == ST_COPY) && seq_active && (op_q == OP_FE);
  assign done_evt  = (st_q == ST_COPY) && seq_last;
  assign seq_start = (st_q == ST_LOOK) && go_copy;
  assign key       = (op_q == OP_ST) ? w1 : id_q;

  erc_stage_buf #(.DEPTH(BUF_WORDS)) u_buf (
    .clk(clk), .host_we(buf_we && !busy), .host_addr(buf_addr),
    .host_wdata(buf_wdata), .host_rdata(buf_rdata),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(store_rd),
    .eng_rdata0(w0), .eng_rdata1(w1)
  );

  erc_copy_seq #(.RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .active(seq_active), .cnt(seq_cnt), .last(seq_last)
  );

  erc_slot_lookup #(.NSLOT(NSLOT)) u_look (
    .occ(occ_q), .ids(sid_q), .key(key), .cur(slot_q),
    .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx),
    .first_idx(first_idx), .next_any(next_any), .next_idx(next_idx)
  );

  // Lookup-stage decision for the open operation
  always_comb begin
    go_copy = 1'b0; pick_new = 1'b0; pick_slot = '0;
    drop_slot = 1'b0; load_first = 1'b0; look_status = STS_FAIL;
    case (op_q)
      OP_ST: begin
        if (hdr_ok(w0) && w1 != '0) begin
          if (hit) begin
            go_copy = 1'b1; pick_slot = hit_idx;
          end else if (free_any) begin
            go_copy = 1'b1; pick_slot = free_idx; pick_new = 1'b1;
          end
        end
      end
      OP_FE: begin
        if (count_q == '0) begin
          look_status = STS_EMPTY;
        end else if (id_q == '0) begin
          go_copy = 1'b1; pick_slot = first_idx;
        end else if (hit) begin
          go_copy = 1'b1; pick_slot = hit_idx;
        end else begin
          look_status = STS_NOREC; load_first = 1'b1;
        end
      end
      OP_DI: begin
        if (id_q == '0) begin
          look_status = STS_FAIL;
        end else if (hit) begin
          drop_slot = 1'b1; pick_slot = hit_idx; look_status = STS_OK;
        end else begin
          look_status = STS_NOREC;
        end
      end
      default: look_status = STS_FAIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (store_we) store_mem[store_addr] <= w0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;   op_q <= OP_NONE;
      off_q <= '0;       id_q <= '0;
      status_q <= STS_OK; count_q <= '0;
      slot_q <= '0;      new_q <= 1'b0;
      wid_q <= '0;       occ_q <= '0;
      sid_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (act_valid) begin
          case (act_code)
            A_OPEN_ST: op_q  <= OP_ST;
            A_OPEN_FE: op_q  <= OP_FE;
            A_OPEN_DI: op_q  <= OP_DI;
            A_SET_OFF: off_q <= act_data[BAW-1:0];
            A_SET_ID:  id_q  <= act_data;
            A_EXEC:    st_q  <= ST_LOOK;
            A_CLOSE:   op_q  <= OP_NONE;
            default: ;
          endcase
        end
        ST_LOOK: begin
          if (go_copy) begin
            st_q   <= ST_COPY;
            slot_q <= pick_slot;
            new_q  <= pick_new;
            wid_q  <= w1;
          end else begin
            st_q     <= ST_IDLE;
            status_q <= look_status;
            if (load_first) id_q <= sid_q[first_idx];
            if (drop_slot) begin
              occ_q[pick_slot] <= 1'b0;
              count_q <= count_q - CNTW'(1);
            end
          end
        end
        ST_COPY: if (seq_last) begin
          st_q     <= ST_IDLE;
          status_q <= STS_OK;
          if (op_q == OP_ST) begin
            occ_q[slot_q] <= 1'b1;
            sid_q[slot_q] <= wid_q;
            if (new_q) count_q <= count_q + CNTW'(1);
          end else begin
            id_q <= next_any ? sid_q[next_idx] : end_marker();
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (act_code)
      A_Q_BUSY: act_rdata = {63'd0, busy};
      A_Q_STAT: act_rdata = {56'd0, status_q};
      A_Q_ID:   act_rdata = id_q;
      default:  act_rdata = '0;
    endcase
  end
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int NSLOT = 4,
  parameter int CNTW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            act_valid,
  input logic [3:0]      act_code,
  input logic [CNTW-1:0] rec_count,
  input logic [7:0]      status,
  input logic            store_we,
  input logic            eng_we,
  input logic            done_evt
);
  // R2
  exec_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == 4'd5 && !busy) |=> busy);

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |-> $past(busy));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rec_count) <= NSLOT);

  // R4
  count_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_count != $past(rec_count)) |-> $past(busy));

  // R13
  engine_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_we || eng_we || done_evt) |-> busy);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
endmodule

bind erc_top erc_checker #(.NSLOT(NSLOT), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .act_valid(act_valid),
  .act_code(act_code), .rec_count(rec_count), .status(status_q),
  .store_we(store_we), .eng_we(eng_we), .done_evt(done_evt)
);

// File: tb/erc_top_tb.sv
`timescale 1ns/1ps
module erc_top_tb;
  localparam int NSLOT = 4, RW = 4, BUFW = 16;
  localparam int BAW = $clog2(BUFW), CNTW = $clog2(NSLOT + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic act_valid = 1'b0;
  logic [3:0] act_code = 4'd0;
  logic [63:0] act_data = '0, act_rdata;
  logic buf_we = 1'b0;
  logic [BAW-1:0] buf_addr = '0;
  logic [63:0] buf_wdata = '0, buf_rdata;
  logic busy;
  logic [CNTW-1:0] rec_count;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  erc_top #(.NSLOT(NSLOT), .RW(RW), .BUF_WORDS(BUFW)) u_dut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] rec_word(logic [63:0] id, logic [15:0] tag, int k);
    case (k)
      0: return {16'd0, tag, 16'h0, 16'h5245};
      1: return id;
      2: return id ^ 64'hA5A5_5A5A_0F0F_F0F0;
      default: return {tag, 16'hBEEF, id[31:0]};
    endcase
  endfunction

  task automatic act(logic [3:0] code, logic [63:0] data);
    @(negedge clk);
    act_valid = 1'b1; act_code = code; act_data = data;
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  task automatic query(logic [3:0] code, output logic [63:0] r);
    @(negedge clk);
    act_code = code;
    #1 r = act_rdata;
  endtask

  task automatic bwrite(int a, logic [63:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = BAW'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic bread(int a, output logic [63:0] d);
    @(negedge clk);
    buf_addr = BAW'(a);
    #1 d = buf_rdata;
  endtask

  task automatic load_rec(int off, logic [63:0] id, logic [15:0] tag);
    for (int k = 0; k < RW; k++) bwrite(off + k, rec_word(id, tag, k));
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic run_op(logic [3:0] open, int off, logic [63:0] id, output logic [7:0] sts);
    logic [63:0] r;
    act(open, '0);
    act(4'd3, 64'(off));
    act(4'd4, id);
    act(4'd5, '0);
    wait_idle();
    query(4'd7, r);
    sts = r[7:0];
    act(4'd9, '0);
  endtask

  task automatic check_rec(string req, int off, logic [63:0] id, logic [15:0] tag);
    logic [63:0] d;
    for (int k = 0; k < RW; k++) begin
      bread(off + k, d);
      check(req, d, rec_word(id, tag, k));
    end
  endtask

  task automatic t_reset();
    logic [63:0] r;
    check("R1 busy", 64'(busy), 0);
    check("R1 count", 64'(rec_count), 0);
    query(4'd7, r); check("R1 status", r, 0);
    query(4'd8, r); check("R1 id", r, 0);
  endtask

  task automatic t_no_open_and_empty();
    logic [63:0] r; logic [7:0] s;
    act(4'd5, '0); wait_idle();
    query(4'd7, r); check("R14 exec without open", r, 3);
    run_op(4'd1, 0, 64'h0, s); check("R10 empty fetch", 64'(s), 4);
  endtask

  task automatic t_bad_store();
    logic [7:0] s;
    bwrite(0, 64'h0000_1111_0000_4552);
    bwrite(1, 64'h51);
    run_op(4'd0, 0, 0, s); check("R3 bad signature", 64'(s), 3);
    check("R3 count", 64'(rec_count), 0);
    load_rec(0, 64'h0, 16'h1);
    run_op(4'd0, 0, 0, s); check("R3 zero id", 64'(s), 3);
    check("R3 count", 64'(rec_count), 0);
  endtask

  task automatic t_store_new();
    logic [63:0] r; logic [7:0] s;
    load_rec(0, 64'h11, 16'hA1);
    act(4'd0, '0); act(4'd3, 0); act(4'd5, '0);
    check("R2 busy after execute", 64'(busy), 1);
    #1 act_code = 4'd6; #1 check("R2 busy query", act_rdata, 1);
    wait_idle();
    check("R2 busy cleared", 64'(busy), 0);
    query(4'd7, r); check("R4 status", r, 0);
    act(4'd9, '0);
    check("R4 count 1", 64'(rec_count), 1);
    load_rec(0, 64'h22, 16'hA2); run_op(4'd0, 0, 0, s);
    load_rec(0, 64'h33, 16'hA3); run_op(4'd0, 0, 0, s);
    check("R4 count 3", 64'(rec_count), 3);
  endtask

  task automatic t_replace();
    logic [7:0] s;
    load_rec(0, 64'h22, 16'hB2); run_op(4'd0, 0, 0, s);
    check("R5 status", 64'(s), 0);
    check("R5 count unchanged", 64'(rec_count), 3);
    run_op(4'd1, 8, 64'h22, s);
    check("R8 status", 64'(s), 0);
    check_rec("R8 R5 copied words", 8, 64'h22, 16'hB2);
  endtask

  task automatic t_full();
    logic [7:0] s;
    load_rec(0, 64'h44, 16'hA4); run_op(4'd0, 0, 0, s);
    check("R4 count 4", 64'(rec_count), 4);
    load_rec(0, 64'h55, 16'hA5); run_op(4'd0, 0, 0, s);
    check("R6 status", 64'(s), 3);
    check("R6 count", 64'(rec_count), 4);
  endtask

  task automatic t_fetch_iter();
    logic [63:0] r; logic [7:0] s;
    run_op(4'd1, 4, 64'h0, s);
    check("R7 status", 64'(s), 0);
    check_rec("R7 first record", 4, 64'h11, 16'hA1);
    query(4'd8, r); check("R11 next id", r, 64'h22);
    run_op(4'd1, 4, 64'h44, s);
    check_rec("R8 last record", 4, 64'h44, 16'hA4);
    query(4'd8, r); check("R11 end marker", r, {64{1'b1}});
  endtask

  task automatic t_missing();
    logic [63:0] r, d; logic [7:0] s;
    for (int k = 0; k < RW; k++) bwrite(12 + k, 64'hC0DE_0000 + 64'(k));
    run_op(4'd1, 12, 64'h99, s);
    check("R9 status", 64'(s), 5);
    query(4'd8, r); check("R9 first id", r, 64'h11);
    for (int k = 0; k < RW; k++) begin
      bread(12 + k, d); check("R9 buffer untouched", d, 64'hC0DE_0000 + 64'(k));
    end
  endtask

  task automatic t_discard();
    logic [63:0] r; logic [7:0] s;
    run_op(4'd2, 0, 64'h0, s); check("R12 zero id", 64'(s), 3);
    run_op(4'd2, 0, 64'h77, s); check("R12 missing", 64'(s), 5);
    check("R12 count kept", 64'(rec_count), 4);
    run_op(4'd2, 0, 64'h11, s); check("R12 status", 64'(s), 0);
    check("R12 count", 64'(rec_count), 3);
    run_op(4'd1, 4, 64'h0, s);
    check_rec("R12 R7 first after discard", 4, 64'h22, 16'hB2);
    query(4'd8, r); check("R11 next after discard", r, 64'h33);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] r, d;
    load_rec(0, 64'h33, 16'hC3);
    act(4'd0, '0); act(4'd3, 0); act(4'd4, 64'h5); act(4'd5, '0);
    act(4'd4, 64'hAB);
    bwrite(15, 64'hDEAD);
    wait_idle();
    query(4'd8, r); check("R13 id kept", r, 64'h5);
    bread(15, d); check("R13 buffer write dropped", d, 64'hC0DE_0003);
    query(4'd7, r); check("R5 replace status", r, 0);
    act(4'd9, '0);
    check("R13 count", 64'(rec_count), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_open_and_empty();
    t_bad_store();
    t_store_new();
    t_replace();
    t_full();
    t_fetch_iter();
    t_missing();
    t_discard();
    t_busy_ignore();
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule